// File: doc/BRIEF.md
# Microprogram Address Sequencer with Return Register

This block produces the address of the next word to fetch from a read-only control store. It holds a 10-bit address, which reaches up to 1024 words. On each accepted advance it either steps forward, jumps, branches on a condition or returns from a subroutine. A plain step changes only the low five address bits. Execution therefore circles inside a 32-word ring until a transfer moves it somewhere else.

One return register gives a single level of subroutine nesting. A save command copies the current address into it. A restore command later loads that value back into the address. The block also drives a timing strobe that the other units use to pace themselves on fresh addresses.

All commands count only in a cycle where `adv` is high. When several commands arrive together, the order is: unconditional jump, then restore, then a conditional branch whose condition is true, then the ring step. Save is independent of that order. It always captures the address held before the edge.

The timing generator is a two-state machine. `ST_IDLE` moves to `ST_ISSUE` on an accepted advance. `ST_ISSUE` stays in `ST_ISSUE` on another advance and returns to `ST_IDLE` without one. The strobe is high while the machine is in `ST_ISSUE`.

Top module: `useq_addr_gen`

## Requirements
- R1: After reset the address is 0, the return register holds 0 and the timing strobe is low.
- R2: While `adv` is low the address and the return register keep their values, whatever the other command inputs do.
- R3: A step adds one to address bits [4:0], wrapping from 31 to 0, and leaves bits [9:5] unchanged. Thirty-two steps in a row bring the address back to its starting value.
- R4: An accepted unconditional jump loads all ten bits of `jmp_target` into the address.
- R5: An accepted conditional branch with `cond` high replaces address bits [3:0] with `br_target` and keeps bits [9:4].
- R6: A conditional branch with `cond` low behaves exactly as a step.
- R7: An accepted `save` copies the address held before the edge into the return register. An accepted `restore` loads the return register into the address.
- R8: Priority among simultaneous commands is jump, then restore, then a true conditional branch, then step.
- R9: The timing strobe is high in the cycle after each accepted advance and low in the cycle after any cycle where `adv` is low.
- R10: `save` and `restore` in the same accepted cycle swap the two values. The address takes the old return value and the return register takes the old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Advance strobe; qualifies every command |
| jmp | input | 1 | Unconditional jump request |
| jmp_target | input | 10 | Full target for an unconditional jump |
| br | input | 1 | Conditional branch request |
| br_target | input | 4 | Low-bit target for a conditional branch |
| cond | input | 1 | Branch condition |
| save | input | 1 | Copy the current address into the return register |
| restore | input | 1 | Load the return register into the address |
| addr | output | 10 | Current control-store address |
| tstrobe | output | 1 | Timing strobe for other units |

## Verification
Embedded properties check the following on every cycle: the address holds while idle, the upper bits survive a step, jumps load the full target, and true branches keep the upper six bits. They also check that save captures the prior address and that the strobe follows the advance by one cycle. Some behaviours only the bench's sequences can show. These are the ring closing on itself after thirty-two steps, the priority outcome when all commands collide, the save/restore swap, and the return register being cleared by reset as seen through a later restore.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_JUMP,
        OP_RESTORE,
        OP_BRANCH,
        OP_STEP
    } useq_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } useq_tstate_e;
endpackage

// File: rtl/useq_arbiter.sv
module useq_arbiter
    import useq_pkg::*;
(
    input  logic     adv,
    input  logic     jmp,
    input  logic     restore,
    input  logic     br,
    input  logic     cond,
    output useq_op_e op
);
    always_comb begin
        if (!adv)
            op = OP_HOLD;
        else if (jmp)
            op = OP_JUMP;
        else if (restore)
            op = OP_RESTORE;
        else if (br && cond)
            op = OP_BRANCH;
        else
            op = OP_STEP;
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RING_W = 5,
    parameter int BR_W   = 4
) (
    input  useq_op_e          op,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic [BR_W-1:0]   br_target,
    input  logic [ADDR_W-1:0] ret_q,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] branched;
    logic [RING_W-1:0] ring_low;

    assign ring_low = cur[RING_W-1:0] + {{(RING_W-1){1'b0}}, 1'b1};

    generate
        if (RING_W < ADDR_W) begin : g_ring_part
            assign stepped = {cur[ADDR_W-1:RING_W], ring_low};
        end else begin : g_ring_full
            assign stepped = ring_low;
        end
        if (BR_W < ADDR_W) begin : g_br_part
            assign branched = {cur[ADDR_W-1:BR_W], br_target};
        end else begin : g_br_full
            assign branched = br_target;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_HOLD:    nxt = cur;
            OP_JUMP:    nxt = jmp_target;
            OP_RESTORE: nxt = ret_q;
            OP_BRANCH:  nxt = branched;
            OP_STEP:    nxt = stepped;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/useq_timing.sv
module useq_timing
    import useq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tstrobe
);
    useq_tstate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = adv ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = adv ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tstrobe = (state_q == ST_ISSUE);
    end

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> tstrobe) else $error("strobe missing"); // R9
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> !tstrobe) else $error("strobe spurious"); // R9
endmodule

// File: rtl/useq_addr_gen.sv
module useq_addr_gen
    import useq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RING_W = 5,
    parameter int BR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              jmp,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic              br,
    input  logic [BR_W-1:0]   br_target,
    input  logic              cond,
    input  logic              save,
    input  logic              restore,
    output logic [ADDR_W-1:0] addr,
    output logic              tstrobe
);
    useq_op_e          op;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [ADDR_W-1:0] ret_q;

    useq_arbiter u_arb (
        .adv     (adv),
        .jmp     (jmp),
        .restore (restore),
        .br      (br),
        .cond    (cond),
        .op      (op)
    );

    useq_next #(.ADDR_W(ADDR_W), .RING_W(RING_W), .BR_W(BR_W)) u_next (
        .op         (op),
        .cur        (addr_q),
        .jmp_target (jmp_target),
        .br_target  (br_target),
        .ret_q      (ret_q),
        .nxt        (addr_d)
    );

    useq_timing u_tim (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .tstrobe (tstrobe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ret_q <= '0;
        else if (adv && save)
            ret_q <= addr_q;
    end

    assign addr = addr_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(addr) && $stable(ret_q))) else $error("idle change"); // R2
    AST_STEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !jmp && !restore && !(br && cond))
        |=> addr[ADDR_W-1:RING_W] == $past(addr[ADDR_W-1:RING_W])) else $error("ring escape"); // R3
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && jmp) |=> addr == $past(jmp_target)) else $error("jump target"); // R4
    AST_BRANCH_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !jmp && !restore && br && cond)
        |=> (addr[ADDR_W-1:BR_W] == $past(addr[ADDR_W-1:BR_W])
             && addr[BR_W-1:0] == $past(br_target))) else $error("branch merge"); // R5
    AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && save) |=> ret_q == $past(addr)) else $error("save capture"); // R7
endmodule

// File: tb/useq_addr_gen_tb.sv
module useq_addr_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       adv, jmp, br, cond, save, restore;
    logic [9:0] jmp_target;
    logic [3:0] br_target;
    logic [9:0] addr;
    logic       tstrobe;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    useq_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .jmp(jmp), .jmp_target(jmp_target),
        .br(br), .br_target(br_target), .cond(cond), .save(save),
        .restore(restore), .addr(addr), .tstrobe(tstrobe)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       a;
        logic       j;
        logic [9:0] ja;
        logic       b;
        logic [3:0] ba;
        logic       c;
        logic       s;
        logic       r;
        logic [9:0] ex;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h001}, // R3 step
        '{4'd2,  1'b0, 1'b1, 10'h2AA, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 10'h001}, // R2 idle
        '{4'd4,  1'b1, 1'b1, 10'h3FD, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h3FD}, // R4 jump
        '{4'd3,  1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h3FE}, // R3
        '{4'd3,  1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h3FF}, // R3
        '{4'd3,  1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h3E0}, // R3 wrap
        '{4'd5,  1'b1, 1'b0, 10'h000, 1'b1, 4'hA, 1'b1, 1'b0, 1'b0, 10'h3EA}, // R5
        '{4'd6,  1'b1, 1'b0, 10'h000, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 10'h3EB}, // R6
        '{4'd7,  1'b1, 1'b1, 10'h155, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 10'h155}, // R7 call
        '{4'd3,  1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h156}, // R3
        '{4'd7,  1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 10'h3EB}, // R7 return
        '{4'd8,  1'b1, 1'b1, 10'h0C0, 1'b1, 4'h3, 1'b1, 1'b0, 1'b1, 10'h0C0}, // R8 jump wins
        '{4'd8,  1'b1, 1'b0, 10'h000, 1'b1, 4'h3, 1'b1, 1'b0, 1'b1, 10'h3EB}, // R8 restore wins
        '{4'd5,  1'b1, 1'b0, 10'h000, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0, 10'h3EF}, // R5
        '{4'd10, 1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 10'h3EB}, // R10 swap
        '{4'd10, 1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 10'h3EF}, // R10 old addr
        '{4'd4,  1'b1, 1'b1, 10'h01F, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h01F}, // R4
        '{4'd3,  1'b1, 1'b0, 10'h000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h000}, // R3 wrap
        '{4'd2,  1'b0, 1'b0, 10'h000, 1'b1, 4'h9, 1'b1, 1'b1, 1'b0, 10'h000}  // R2 idle
    };

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic j, input logic [9:0] ja, input logic b,
                         input logic [3:0] ba, input logic c, input logic s, input logic r);
        adv = a; jmp = j; jmp_target = ja; br = b; br_target = ba;
        cond = c; save = s; restore = r;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        adv = 0; jmp = 0; jmp_target = '0; br = 0; br_target = '0;
        cond = 0; save = 0; restore = 0;
        repeat (3) @(negedge clk);
        check("R1 addr", addr, 10'h000);
        check("R1 strobe", {9'd0, tstrobe}, 10'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].a, VECS[i].j, VECS[i].ja, VECS[i].b, VECS[i].ba,
                  VECS[i].c, VECS[i].s, VECS[i].r);
            check($sformatf("R%0d vec%0d addr", VECS[i].req, i), addr, VECS[i].ex);
            check($sformatf("R9 vec%0d strobe", i), {9'd0, tstrobe}, {9'd0, VECS[i].a});
        end

        // R3: full ring of 32 steps returns to start
        drive(1, 1, 10'h2A0, 0, 0, 0, 0, 0);
        for (int k = 1; k <= 32; k++) begin
            drive(1, 0, 0, 0, 0, 0, 0, 0);
            check($sformatf("R3 ring step%0d", k), addr, {5'b10101, 5'(k % 32)});
        end

        // R1: reset mid-run clears return register (seen via restore)
        drive(1, 0, 0, 0, 0, 0, 1, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 addr after reset", addr, 10'h000);
        check("R1 strobe after reset", {9'd0, tstrobe}, 10'd0);
        rst_n = 1'b1;
        drive(1, 1, 10'h123, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0, 1);
        check("R1 return register cleared", addr, 10'h000);

        // R9: strobe drops after idle cycle
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        check("R9 strobe low", {9'd0, tstrobe}, 10'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule